// File: doc/BRIEF.md
# Ringing and Ring-Trip Confirmation Sequencer

This block decides when ringing current is put on a subscriber line and when an answered call counts as a ring trip. It takes a three-bit mode code from a command write, a one-cycle strobe at each zero crossing of the low-frequency ringing reference, and a raw loop-closed level from the line stage. It produces a ringing gate for the line driver and a ring-trip flag for status.

Ringing starts and stops only on a zero-crossing strobe, so the line never sees a clipped first or last cycle. When the handset lifts during ringing, the gate drops at once but the block stays in ringing mode. It then counts zero-crossing strobes while the loop stays closed. Four strobes make two full periods at whatever ringing frequency is present. If the loop stays closed for all four, the trip flag is raised and the block holds silent until the next command. If the loop opens before then, ringing resumes at the next crossing with the flag clear.

Top module: `ring_trip_seq`

## Requirements
- R1: After reset, ring_en and trip_flag are both 0.
- R2: Ringing is requested only by the mode code 3'b110 (bit 2 = 1, bit 1 = 1, bit 0 = 0). Any other code, including 3'b100 and 3'b111, never raises ring_en.
- R3: After a write of 3'b110 while ring_en is 0, ring_en stays 0 until a zc_strobe is sampled. It goes to 1 in the cycle after that strobe.
- R4: A write of a non-ringing code while ring_en is 1 keeps ring_en at 1 until a zc_strobe is sampled. ring_en goes to 0 in the cycle after that strobe.
- R5: When loop_closed is sampled high while ringing with no command write in that cycle, ring_en goes to 0 in the next cycle, without waiting for a zero crossing.
- R6: After such a suspension, if loop_closed stays high through four zc_strobe pulses (counted from the cycle after suspension), trip_flag goes to 1 in the cycle after the fourth strobe and ring_en stays 0.
- R7: If loop_closed is sampled low before the fourth strobe, trip_flag stays 0 and ring_en stays 0. ringing then resumes in the cycle after the next zc_strobe sampled after the abort.
- R8: While trip_flag is 1 and no command is written, trip_flag stays 1 and ring_en stays 0, whatever zc_strobe and loop_closed do.
- R9: Any command write clears trip_flag in the next cycle and moves to the newly selected mode. A write of 3'b110 then waits for a zero crossing as in R3.
- R10: If loop_closed is sampled high while a stop is pending (R4), ring_en drops in the next cycle and no trip check follows: trip_flag stays 0.
- R11: A command write takes priority over zc_strobe and loop_closed in the same cycle. Those inputs have no effect in a write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | One-cycle strobe: a new command word is present |
| cmd_mode | input | 3 | Mode bits of the command word |
| zc_strobe | input | 1 | One-cycle pulse at each zero crossing of the ringing reference |
| loop_closed | input | 1 | Raw off-hook indication from the line stage |
| ring_en | output | 1 | Ringing gate to the line driver |
| trip_flag | output | 1 | Ring trip confirmed |

## Verification
Several properties are checked on every cycle:
- the gate rises only in the cycle after a zero crossing;
- the gate falls only after a crossing or a closure;
- a closure with no write always silences the line;
- the trip flag rises only on a crossing with the loop closed, and then stays set and silent until a write;
- a write always clears the flag.

The exact count of four strobes, the abort and resume path, the stop-pending closure and the write-priority cases are shown only by the bench's scenarios. Each scenario is compared against the behavioural model on every clock.

// File: rtl/ring_trip_seq.sv
module ring_trip_seq #(
  parameter int ZC_PER_WINDOW = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [2:0] cmd_mode,
  input  logic       zc_strobe,
  input  logic       loop_closed,
  output logic       ring_en,
  output logic       trip_flag
);

  localparam int CW = $clog2(ZC_PER_WINDOW + 1);
  localparam logic [CW-1:0] LAST_ZC = CW'(ZC_PER_WINDOW - 1);

  typedef enum logic [2:0] {
    S_IDLE,
    S_ARM,
    S_RING,
    S_DRAIN,
    S_CHECK,
    S_HOLD
  } st_t;

  st_t st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic ring_req;

  assign ring_req  = (cmd_mode == 3'b110);
  assign ring_en   = (st == S_RING) || (st == S_DRAIN);
  assign trip_flag = (st == S_HOLD);

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    if (cmd_wr) begin
      cnt_n = '0;
      if (ring_en) st_n = ring_req ? S_RING : S_DRAIN;
      else         st_n = ring_req ? S_ARM  : S_IDLE;
    end else begin
      case (st)
        S_ARM:   if (zc_strobe) st_n = S_RING;
        S_RING:  if (loop_closed) begin
                   st_n  = S_CHECK;
                   cnt_n = '0;
                 end
        S_DRAIN: if (loop_closed || zc_strobe) st_n = S_IDLE;
        S_CHECK: if (!loop_closed) st_n = S_ARM;
                 else if (zc_strobe) begin
                   if (cnt == LAST_ZC) st_n = S_HOLD;
                   else cnt_n = cnt + 1'b1;
                 end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
    end
  end

  // R3
  ring_start_on_zc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ring_en) |-> $past(zc_strobe));

  // R4
  ring_stop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ring_en) |-> ($past(zc_strobe) || $past(loop_closed)));

  // R5
  closure_suspends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_en && loop_closed && !cmd_wr) |=> !ring_en);

  // R6
  trip_needs_zc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_flag) |-> ($past(zc_strobe) && $past(loop_closed)));

  // R6
  window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(ZC_PER_WINDOW));

  // R8
  hold_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_flag |-> !ring_en);

  // R8
  hold_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_flag && !cmd_wr) |=> trip_flag);

  // R9
  cmd_clears_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> !trip_flag);

  // R2
  no_ring_bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_mode != 3'b110 && !ring_en) |=> !ring_en);

endmodule

// File: tb/ring_trip_seq_bench.sv
`timescale 1ns/1ps
module ring_trip_seq_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic cmd_wr = 0;
  logic [2:0] cmd_mode = 3'b000;
  logic zc_strobe = 0;
  logic loop_closed = 0;
  logic ring_en, trip_flag;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  ring_trip_seq u_ring_trip_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_mode(cmd_mode),
    .zc_strobe(zc_strobe), .loop_closed(loop_closed),
    .ring_en(ring_en), .trip_flag(trip_flag)
  );

  bit m_on, m_stop, m_wait, m_checking, m_trip;
  int m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_on = 0; m_stop = 0; m_wait = 0; m_checking = 0; m_trip = 0; m_cnt = 0;
    end else if (cmd_wr) begin
      m_trip = 0;
      m_checking = 0;
      if (m_on) m_stop = (cmd_mode != 3'b110);
      else m_wait = (cmd_mode == 3'b110);
    end else if (m_on) begin
      if (loop_closed) begin
        m_on = 0;
        if (!m_stop) begin m_checking = 1; m_cnt = 0; end
        m_stop = 0;
      end else if (m_stop && zc_strobe) begin
        m_on = 0; m_stop = 0;
      end
    end else if (m_checking) begin
      if (!loop_closed) begin
        m_checking = 0; m_wait = 1;
      end else if (zc_strobe) begin
        m_cnt++;
        if (m_cnt == 4) begin m_checking = 0; m_trip = 1; end
      end
    end else if (m_wait && zc_strobe) begin
      m_wait = 0; m_on = 1;
    end
  end

  task automatic chk(input logic act, input logic exp, input string t);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(ring_en, m_on, {tag, " model ring_en"});
      chk(trip_flag, m_trip, {tag, " model trip_flag"});
    end
  end

  task automatic cyc(input bit z, input bit l, input bit w, input logic [2:0] m);
    @(negedge clk);
    zc_strobe = z; loop_closed = l; cmd_wr = w; cmd_mode = m;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc(0,0,0,3'b000);
    chk(ring_en, 0, "R1 ring_en after reset");
    chk(trip_flag, 0, "R1 trip_flag after reset");

    tag = "R2";
    cyc(0,0,1,3'b100);
    for (int i = 0; i < 3; i++) begin cyc(1,0,0,3'b100); cyc(0,0,0,3'b100); end
    chk(ring_en, 0, "R2 code 100 no ringing");
    cyc(0,0,1,3'b111);
    for (int i = 0; i < 3; i++) begin cyc(1,0,0,3'b111); cyc(0,0,0,3'b111); end
    chk(ring_en, 0, "R2 code 111 no ringing");

    tag = "R3";
    cyc(0,0,1,3'b110);
    for (int i = 0; i < 3; i++) cyc(0,0,0,3'b110);
    chk(ring_en, 0, "R3 waits for zero crossing");
    cyc(1,0,0,3'b110); cyc(0,0,0,3'b110);
    chk(ring_en, 1, "R3 starts after zero crossing");

    tag = "R5";
    cyc(0,1,0,3'b110); cyc(0,1,0,3'b110);
    chk(ring_en, 0, "R5 closure suspends at once");
    tag = "R6";
    for (int i = 0; i < 3; i++) begin cyc(1,1,0,3'b110); cyc(0,1,0,3'b110); end
    chk(trip_flag, 0, "R6 not confirmed after three strobes");
    cyc(1,1,0,3'b110); cyc(0,1,0,3'b110);
    chk(trip_flag, 1, "R6 confirmed after fourth strobe");
    chk(ring_en, 0, "R6 ringing off when confirmed");

    tag = "R8";
    cyc(1,0,0,3'b110); cyc(1,1,0,3'b110); cyc(0,0,0,3'b110); cyc(1,0,0,3'b110); cyc(0,0,0,3'b110);
    chk(trip_flag, 1, "R8 flag holds");
    chk(ring_en, 0, "R8 stays silent");

    tag = "R9";
    cyc(0,0,1,3'b110); cyc(0,0,0,3'b110);
    chk(trip_flag, 0, "R9 write clears flag");
    chk(ring_en, 0, "R9 new ring waits for crossing");
    cyc(1,0,0,3'b110); cyc(0,0,0,3'b110);
    chk(ring_en, 1, "R9 ringing restarted");

    tag = "R7";
    cyc(0,1,0,3'b110);
    cyc(1,1,0,3'b110); cyc(0,1,0,3'b110); cyc(1,1,0,3'b110); cyc(0,1,0,3'b110);
    cyc(0,0,0,3'b110); cyc(0,0,0,3'b110);
    chk(ring_en, 0, "R7 silent after abort");
    chk(trip_flag, 0, "R7 flag clear after abort");
    cyc(0,0,0,3'b110); cyc(0,0,0,3'b110);
    chk(ring_en, 0, "R7 resume waits for crossing");
    cyc(1,0,0,3'b110); cyc(0,0,0,3'b110);
    chk(ring_en, 1, "R7 ringing resumed");

    tag = "R4";
    cyc(0,0,1,3'b100); cyc(0,0,0,3'b100);
    chk(ring_en, 1, "R4 stop pending keeps ringing");
    tag = "R10";
    cyc(0,1,0,3'b100); cyc(0,1,0,3'b100);
    chk(ring_en, 0, "R10 closure while stop pending");
    for (int i = 0; i < 5; i++) begin cyc(1,1,0,3'b100); cyc(0,1,0,3'b100); end
    chk(trip_flag, 0, "R10 no trip check");

    tag = "R4";
    cyc(0,0,1,3'b110); cyc(1,0,0,3'b110); cyc(0,0,0,3'b110);
    chk(ring_en, 1, "R4 ringing before stop");
    cyc(0,0,1,3'b000);
    for (int i = 0; i < 3; i++) cyc(0,0,0,3'b000);
    chk(ring_en, 1, "R4 holds until crossing");
    cyc(1,0,0,3'b000); cyc(0,0,0,3'b000);
    chk(ring_en, 0, "R4 stops after crossing");

    tag = "R11";
    cyc(0,0,1,3'b110); cyc(1,0,0,3'b110); cyc(0,0,0,3'b110);
    cyc(0,1,1,3'b110); cyc(0,0,0,3'b110);
    chk(ring_en, 1, "R11 write beats closure");
    cyc(0,0,0,3'b110);
    chk(ring_en, 1, "R11 still ringing");
    cyc(0,0,1,3'b000); cyc(1,0,0,3'b000); cyc(0,0,0,3'b000);
    chk(ring_en, 0, "R11 back to idle");
    cyc(0,0,1,3'b110); cyc(1,0,1,3'b000); cyc(0,0,0,3'b000);
    chk(ring_en, 0, "R11 write beats crossing");
    cyc(1,0,0,3'b000); cyc(0,0,0,3'b000);
    chk(ring_en, 0, "R11 idle ignores crossing");

    cyc(0,0,0,3'b000);
    finish_run();
  end
endmodule